// File: doc/BRIEF.md
# Cyclic Waveform Playback Buffer

This block holds one sample pattern in a dual-port memory of 1024 words of 32 bits. A host loads the pattern through a write port. The stream side then plays it back continuously, one word per clock, towards a converter. Both sides use byte addresses. The host writes each word at a byte offset that is a multiple of 4. An internal read pointer walks through the word-aligned byte addresses 0, 4, 8 and so on up to 4092, then starts again at 0.

The read pointer steps by 4 bytes and discards its two low bits when it selects a word. As a result, one full period of the pattern takes exactly 1024 enabled clocks. A counter that stepped by 1 over the same byte space would get this wrong in one of two ways. It would play only a quarter of the pattern if it wrapped at 1024. It would play the pattern four times too slowly if it wrapped at 4096.

The host may load the memory while the stream is running. A write to an address that is not word-aligned is dropped and flagged. A synchronous clear sends playback back to the start of the pattern. Dropping the enable pauses playback in place.

Top module: `wave_loop_buffer`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `out_valid`, `out_wrap` and `misalign_err` are 0. After reset the read pointer is at byte address 0, so the first word streamed is word 0.
- R2: A write with `wr_en`=1 and `wr_addr[1:0]`=0 stores `wr_data` into word index `wr_addr[11:2]`.
- R3: A write with `wr_en`=1 and `wr_addr[1:0]`≠0 leaves the memory unchanged. It sets `misalign_err` on the following clock, and the flag stays at 1 until `rst`.
- R4: When `rd_en`=1 and `rd_clear`=0 at a clock edge, `out_data` after that edge holds the word at the current read byte address and `out_valid` is 1. The pointer then advances by 4.
- R5: The read pointer only ever holds multiples of 4. It moves from 4092 to 0, so with `rd_en` held high the pattern repeats every 1024 clocks.
- R6: `out_wrap` is 1 for exactly the one cycle in which the word from byte address 4092 is on `out_data`, and never without `out_valid`.
- R7: When `rd_en`=0 and `rd_clear`=0, the pointer holds its value. On the next cycle `out_valid` is 0 and `out_data` keeps its previous value.
- R8: When `rd_clear`=1, the pointer returns to 0 whatever `rd_en` is. On the next cycle `out_valid` is 0 and `out_data` holds. Memory contents are unchanged.
- R9: If the host writes the word that the stream reads in the same clock, the stream outputs the old contents. The new value is seen on the next visit to that word.
- R10: Host writes and stream reads proceed in the same cycles without interfering, under any mix of enable, clear and write traffic.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 12 | Host byte address |
| wr_data | input | 32 | Host write word |
| rd_en | input | 1 | Playback enable |
| rd_clear | input | 1 | Return playback to byte address 0 |
| out_data | output | 32 | Streamed sample word |
| out_valid | output | 1 | `out_data` was read on the last clock |
| out_wrap | output | 1 | Current word is the last of the pattern |
| misalign_err | output | 1 | Sticky flag for a dropped unaligned write |

## Verification
Every result of this block is due one clock after the edge that samples its cause:
- stream data, valid and wrap follow the enable and clear at that edge;
- the error flag follows the unaligned write.

The bench drives inputs at the falling edge and updates its reference model at the rising edge. It compares all outputs at the next falling edge, so each comparison lands exactly on the cycle after its stimulus. The pattern period is measured as the number of clocks between successive wrap pulses while playback runs without interruption.

// File: rtl/wlb_pkg.sv
package wlb_pkg;
  typedef enum logic [1:0] {
    WR_IDLE,
    WR_STORE,
    WR_MISALIGN,
    WR_RANGE
  } wr_kind_e;
endpackage

// File: rtl/wlb_dpram.sv
module wlb_dpram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024,
  parameter int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  ridx,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  // Write port.
  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  // Read port: registered, read-before-write on a same-word collision.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[ridx];
  end
endmodule

// File: rtl/wlb_host_decode.sv
module wlb_host_decode
  import wlb_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LSB_W  = 2,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = IDX_W + LSB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              we_o,
  output logic [IDX_W-1:0]  widx_o,
  output logic              err_o
);
  localparam logic [IDX_W:0] DEPTH_L = (IDX_W+1)'(DEPTH);

  wr_kind_e kind;

  assign widx_o = wr_addr[ADDR_W-1:LSB_W];

  always_comb begin
    if (!wr_en)                                kind = WR_IDLE;
    else if (wr_addr[LSB_W-1:0] != '0)         kind = WR_MISALIGN;
    else if ({1'b0, widx_o} >= DEPTH_L)        kind = WR_RANGE;
    else                                       kind = WR_STORE;
  end

  assign we_o = (kind == WR_STORE);

  always_ff @(posedge clk) begin
    if (rst)                       err_o <= 1'b0;
    else if (kind == WR_MISALIGN)  err_o <= 1'b1;
  end
endmodule

// File: rtl/wlb_read_seq.sv
module wlb_read_seq #(
  parameter int DEPTH  = 1024,
  parameter int LSB_W  = 2,
  parameter int IDX_W  = $clog2(DEPTH),
  parameter int ADDR_W = IDX_W + LSB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              rd_clear,
  output logic              re_o,
  output logic [IDX_W-1:0]  ridx_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              valid_o,
  output logic              wrap_o
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'((DEPTH - 1) << LSB_W);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << LSB_W);

  logic at_last;

  assign re_o    = rd_en && !rd_clear;
  assign ridx_o  = ptr_o[ADDR_W-1:LSB_W];
  assign at_last = (ptr_o == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_o   <= '0;
      valid_o <= 1'b0;
      wrap_o  <= 1'b0;
    end else begin
      valid_o <= re_o;
      wrap_o  <= re_o && at_last;
      if (rd_clear)   ptr_o <= '0;
      else if (rd_en) ptr_o <= at_last ? '0 : ptr_o + STEP;
    end
  end
endmodule

// File: rtl/wave_loop_buffer.sv
module wave_loop_buffer #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024,
  localparam int BPW    = WORD_W / 8,
  localparam int LSB_W  = $clog2(BPW),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int ADDR_W = IDX_W + LSB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              rd_clear,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_wrap,
  output logic              misalign_err
);
  logic              mem_we;
  logic [IDX_W-1:0]  mem_widx;
  logic              mem_re;
  logic [IDX_W-1:0]  mem_ridx;
  logic [ADDR_W-1:0] rd_byte_addr;

  wlb_host_decode #(.DEPTH(DEPTH), .LSB_W(LSB_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_host (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .we_o(mem_we), .widx_o(mem_widx), .err_o(misalign_err)
  );

  wlb_read_seq #(.DEPTH(DEPTH), .LSB_W(LSB_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_clear(rd_clear),
    .re_o(mem_re), .ridx_o(mem_ridx), .ptr_o(rd_byte_addr),
    .valid_o(out_valid), .wrap_o(out_wrap)
  );

  wlb_dpram #(.WORD_W(WORD_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk(clk), .we(mem_we), .widx(mem_widx), .wdata(wr_data),
    .re(mem_re), .ridx(mem_ridx), .rdata(out_data)
  );
endmodule

// File: rtl/wlb_checker.sv
module wlb_checker #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 1024,
  parameter int LSB_W  = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [LSB_W-1:0]  wr_lsb,
  input logic              rd_en,
  input logic              rd_clear,
  input logic [WORD_W-1:0] out_data,
  input logic              out_valid,
  input logic              out_wrap,
  input logic              misalign_err,
  input logic [ADDR_W-1:0] rd_byte_addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'((DEPTH - 1) << LSB_W);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1 << LSB_W);

  a_r1_quiet_after_reset: assert property (@(posedge clk) rst |=> (!out_valid && !out_wrap && !misalign_err));
  a_r3_err_sticky: assert property (@(posedge clk) disable iff (rst) misalign_err |=> misalign_err);
  a_r3_err_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(misalign_err) |-> $past(wr_en && (wr_lsb != '0)));
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (rst) (rd_en && !rd_clear) |=> out_valid);
  a_r5_aligned: assert property (@(posedge clk) disable iff (rst) rd_byte_addr[LSB_W-1:0] == '0);
  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_clear && rd_byte_addr != LAST) |=> (rd_byte_addr == $past(rd_byte_addr) + STEP));
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !rd_clear && rd_byte_addr == LAST) |=> (rd_byte_addr == '0));
  a_r6_wrap_with_valid: assert property (@(posedge clk) disable iff (rst) out_wrap |-> out_valid);
  a_r6_wrap_single: assert property (@(posedge clk) disable iff (rst) out_wrap |=> !out_wrap);
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!rd_en || rd_clear) |=> (!out_valid && $stable(out_data)));
  a_r7_freeze: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !rd_clear) |=> $stable(rd_byte_addr));
  a_r8_clear: assert property (@(posedge clk) disable iff (rst) rd_clear |=> (rd_byte_addr == '0));
endmodule

bind wave_loop_buffer wlb_checker #(
  .WORD_W(WORD_W), .DEPTH(DEPTH), .LSB_W(LSB_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_lsb(wr_addr[LSB_W-1:0]),
  .rd_en(rd_en), .rd_clear(rd_clear), .out_data(out_data),
  .out_valid(out_valid), .out_wrap(out_wrap), .misalign_err(misalign_err),
  .rd_byte_addr(rd_byte_addr)
);

// File: tb/sim_wave_loop_buffer.sv
`timescale 1ns/1ps
module sim_wave_loop_buffer;
  localparam int DEPTH = 1024;
  localparam int LASTB = 4092;

  logic        clk = 1'b0;
  logic        rst, wr_en, rd_en, rd_clear;
  logic [11:0] wr_addr;
  logic [31:0] wr_data, out_data;
  logic        out_valid, out_wrap, misalign_err;

  always #2.5 clk = ~clk;

  wave_loop_buffer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_clear(rd_clear), .out_data(out_data),
    .out_valid(out_valid), .out_wrap(out_wrap), .misalign_err(misalign_err)
  );

  int vectors = 0, miscomp = 0, cyc = 0, last_wrap = -1;
  bit finished = 0, track_period = 0;
  logic [31:0] mmem [DEPTH];
  int mptr = 0;
  bit merr = 0, evalid = 0, ewrap = 0, dknown = 0;
  logic [31:0] edata = '0;

  function automatic logic [31:0] pat(int i);
    return 32'(i) * 32'h9E3779B9 ^ (32'(i) << 16) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit en, bit clr, bit we, logic [11:0] a, logic [31:0] d);
    rd_en = en; rd_clear = clr; wr_en = we; wr_addr = a; wr_data = d;
    @(posedge clk);
    evalid = en && !clr;
    ewrap  = evalid && (mptr == LASTB);
    if (evalid) begin edata = mmem[mptr >> 2]; dknown = 1; end
    if (we) begin
      if (a[1:0] == 2'b00) mmem[a >> 2] = d;
      else merr = 1;
    end
    if (clr)     mptr = 0;
    else if (en) mptr = (mptr == LASTB) ? 0 : mptr + 4;
    @(negedge clk);
    cyc++;
    chk(tag, "out_valid", out_valid, evalid);
    chk(tag, "out_wrap", out_wrap, ewrap);
    chk(tag, "misalign_err", misalign_err, merr);
    if (dknown) chk(tag, "out_data", out_data, edata);
    if (track_period && out_wrap) begin
      if (last_wrap >= 0) chk("R5", "wrap period", cyc - last_wrap, 1024);
      last_wrap = cyc;
    end
    wr_en = 0;
  endtask

  task automatic do_reset();
    rst = 1; wr_en = 0; rd_en = 0; rd_clear = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "valid in reset", out_valid, 0);
    chk("R1", "err in reset", misalign_err, 0);
    rst = 0;
    mptr = 0; merr = 0; evalid = 0; ewrap = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "valid after reset", out_valid, 0);
    chk("R1", "wrap after reset", out_wrap, 0);
    chk("R1", "err after reset", misalign_err, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      miscomp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) mmem[i] = '0;
    do_reset();
    // Load the pattern with playback stopped (R2, R7).
    for (int i = 0; i < DEPTH; i++) step("R2", 0, 0, 1, 12'(i * 4), pat(i));
    // Continuous playback over two periods and a bit (R4, R5, R6).
    track_period = 1;
    for (int i = 0; i < 2 * DEPTH + 10; i++) step("R4", 1, 0, 0, '0, '0);
    track_period = 0;
    // Unaligned write into word 7 is dropped (R3).
    step("R3", 0, 0, 1, 12'(7 * 4 + 2), 32'hDEADBEEF);
    step("R8", 0, 1, 0, '0, '0);
    for (int i = 0; i < 10; i++) step("R3", 1, 0, 0, '0, '0);
    // Clear while enabled, then a same-word collision on word 3 (R8, R9).
    step("R8", 1, 1, 0, '0, '0);
    for (int i = 0; i < 3; i++) step("R9", 1, 0, 0, '0, '0);
    step("R9", 1, 0, 1, 12'd12, 32'hC0FFEE00);
    chk("R9", "collision returns old word", out_data, pat(3));
    for (int i = 0; i < DEPTH + 4; i++) step("R9", 1, 0, 0, '0, '0);
    // Pause in the middle of the pattern (R7).
    for (int i = 0; i < 5; i++) step("R7", 0, 0, 0, '0, '0);
    for (int i = 0; i < 5; i++) step("R7", 1, 0, 0, '0, '0);
    // Mixed random traffic (R10).
    for (int i = 0; i < 20000; i++) begin
      bit en, clr, we;
      logic [11:0] a;
      en  = ($urandom % 4) != 0;
      clr = ($urandom % 32) == 0;
      we  = ($urandom % 10) < 3;
      a   = 12'($urandom % 4096);
      if (($urandom % 5) != 0) a[1:0] = 2'b00;
      step("R10", en, clr, we, a, $urandom);
    end
    // Reset clears the sticky flag (R1).
    do_reset();
    for (int i = 0; i < 4; i++) step("R1", 1, 0, 0, '0, '0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule